// File: doc/BRIEF.md
# UART Data Register Access Interlock

This block sits between a simple register bus and the character path of a UART. The bus side has read and write strobes, an address and 16-bit data. The UART side has a transmit holding register and a one-character receive buffer.

One data address serves both directions:
- A read returns the received character.
- A write offers a character for transmission.

A separate status address reports three flags: transmit holding register empty, receive buffer full, and receiver active.

A data access only takes effect after software has looked at the status word and seen the relevant flag set. A status read arms the transmit side if it saw the empty flag, and arms the receive side if it saw the full flag. An accepted write loads the holding register and consumes the transmit arm. An accepted read pops the receive buffer and consumes the receive arm. An access that is not accepted changes nothing.

FIFO mode bypasses the arming in both directions. Transmit DMA enable bypasses it for writes only, and receive DMA enable bypasses it for reads only. The serial shifter and the start-bit detector are outside the block and are reached through single-cycle handshake pulses.

Top module: `uart_dri_top`

## Requirements
- R1: After reset the transmit-empty flag is 1, the receive-full flag is 0, the receiver-active flag is 0, both arms are clear and `txValid` is 0.
- R2: Addresses and status layout:
  - The status word is at address 0, with bit 0 = transmit empty, bit 1 = receive full, bit 2 = receiver active, and all other bits 0.
  - The data register is at address 1.
  - Reads return data combinationally in the cycle `busRd` is high.
- R3: Data register contents:
  - A data read returns the character in bits 8:0, and bits 15:9 read as 0.
  - With `cfgEightBit` set, bit 8 reads as 0 and a written bit 8 is dropped.
- R4: With no bypass, a data write while transmit-empty is set, made before any status read has seen that flag, is ignored and `txValid` stays 0.
- R5: A status read that sees transmit-empty set arms the transmit side. The next data write then loads `txData` and drops the empty flag (`txValid` = 1). The arm is consumed, so a later write after the shifter takes the character needs a new status read.
- R6: A data write while the holding register is full (empty flag 0) is ignored and `txData` keeps its value. A `txTake` pulse sets the empty flag again.
- R7: With no bypass and no arm, a data read while receive-full is set returns the character but does not pop: `rxPop` stays 0 and the full flag stays 1.
- R8: A status read that sees receive-full set arms the receive side. The next data read asserts `rxPop` in that cycle and clears the full flag.
- R9: With `cfgFifoEn` set, data writes and data reads are accepted without any status read.
- R10: `cfgTxDmaEn` bypasses arming for writes only, and `cfgRxDmaEn` bypasses arming for reads only.
- R11: An arm reflects the flag at the moment of the status read. A status read made while receive-full was 0 does not allow a pop of a character that arrives later.
- R12: Receiver-active behaviour:
  - `rxStartLow` sets receiver-active.
  - `rxFalseStart`, `rxPreamble` or a completed character (`rxPush`) clears it.
  - A clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 status, 1 data) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data |
| cfgFifoEn | input | 1 | FIFO mode, bypasses arming both ways |
| cfgTxDmaEn | input | 1 | Transmit DMA, bypasses write arming |
| cfgRxDmaEn | input | 1 | Receive DMA, bypasses read arming |
| cfgEightBit | input | 1 | 8-bit character format |
| txValid | output | 1 | Holding register full (inverse of transmit-empty) |
| txData | output | 9 | Holding register contents |
| txTake | input | 1 | Shifter has taken the held character |
| rxPush | input | 1 | Receiver delivers a character |
| rxChar | input | 9 | Delivered character |
| rxPop | output | 1 | Receive buffer popped by an accepted read |
| rxStartLow | input | 1 | Low sampled in first slot of start-bit search |
| rxFalseStart | input | 1 | Start bit found to be false |
| rxPreamble | input | 1 | Preamble (idle frame) detected |

## Verification
Some properties are checked by assertions on every cycle:
- A load only happens while the holding register is empty, and it empties nothing in the next cycle.
- A pop only happens while the buffer is full.
- An unbypassed load or pop always has its arm set.
- A status read that sees a flag leaves the matching arm set.
- Receiver-active follows its set and clear pulses.
- The reserved read bits are always zero.

Other behaviour can only be shown by the bench's scenarios:
- Ignored accesses leave `txData` and the full flag untouched.
- An arm is consumed by a single access.
- A stale status read does not arm.
- Each bypass applies to one direction only.
- The 8-bit format masks bit 8 on both paths.

// File: rtl/uart_dri_pkg.sv
package uart_dri_pkg;
  typedef struct packed {
    logic loadTx;
    logic popRx;
  } dri_strobe_t;

  typedef struct packed {
    logic rxActive;
    logic rxFull;
    logic txEmpty;
  } dri_status_t;
endpackage

// File: rtl/uart_dri_ctrl.sv
module uart_dri_ctrl
  import uart_dri_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic        cfgFifoEn,
  input  logic        cfgTxDmaEn,
  input  logic        cfgRxDmaEn,
  input  logic        txTake,
  input  logic        rxPush,
  input  logic        rxStartLow,
  input  logic        rxFalseStart,
  input  logic        rxPreamble,
  output dri_strobe_t strb,
  output dri_status_t stat
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);

  logic txEmpty, rxFull, rxActive, txArm, rxArm;
  logic statRd, dataRd, dataWr, txBypass, rxBypass, rxClear;

  assign statRd   = busRd && (busAddr == StatA);
  assign dataRd   = busRd && (busAddr == DataA);
  assign dataWr   = busWr && (busAddr == DataA);
  assign txBypass = cfgFifoEn || cfgTxDmaEn;
  assign rxBypass = cfgFifoEn || cfgRxDmaEn;
  assign rxClear  = rxFalseStart || rxPreamble || rxPush;

  assign strb.loadTx = dataWr && txEmpty && (txArm || txBypass);
  assign strb.popRx  = dataRd && rxFull && (rxArm || rxBypass);

  assign stat.txEmpty  = txEmpty;
  assign stat.rxFull   = rxFull;
  assign stat.rxActive = rxActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      txArm   <= 1'b0;
    end else begin
      if (strb.loadTx)             txEmpty <= 1'b0;
      else if (txTake && !txEmpty) txEmpty <= 1'b1;

      if (strb.loadTx)   txArm <= 1'b0;
      else if (statRd)   txArm <= txEmpty;
      else if (!txEmpty) txArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxArm  <= 1'b0;
    end else begin
      if (rxPush)           rxFull <= 1'b1;
      else if (strb.popRx)  rxFull <= 1'b0;

      if (strb.popRx)       rxArm <= 1'b0;
      else if (statRd)      rxArm <= rxFull;
      else if (!rxFull)     rxArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxActive <= 1'b0;
    else if (rxClear)    rxActive <= 1'b0;
    else if (rxStartLow) rxActive <= 1'b1;
  end

  assert_load_needs_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |-> txEmpty);
  assert_load_fills_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> !txEmpty);
  assert_unbypassed_load_armed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && !txBypass) |-> txArm);
  assert_pop_needs_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.popRx |-> rxFull);
  assert_unbypassed_pop_armed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popRx && !rxBypass) |-> rxArm);
  assert_status_arms_tx_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && txEmpty) |=> txArm);
  assert_status_arms_rx_R11: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && rxFull) |=> rxArm);
  assert_active_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxStartLow && !rxClear) |=> rxActive);
  assert_active_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |=> !rxActive);
endmodule

// File: rtl/uart_dri_datapath.sv
module uart_dri_datapath
  import uart_dri_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int BUS_W     = 16,
  parameter int CHAR_W    = 9,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic              cfgEightBit,
  input  dri_strobe_t       strb,
  input  dri_status_t       stat,
  input  logic              rxPush,
  input  logic [CHAR_W-1:0] rxChar,
  output logic [CHAR_W-1:0] txData,
  output logic [BUS_W-1:0]  busRdata
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);
  localparam logic [CHAR_W-1:0] FullMask  = '1;
  localparam logic [CHAR_W-1:0] ShortMask = CHAR_W'(8'hFF);

  logic [CHAR_W-1:0] charMask, txHold, rxBuf;

  assign charMask = cfgEightBit ? ShortMask : FullMask;
  assign txData   = txHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      rxBuf  <= '0;
    end else begin
      if (strb.loadTx) txHold <= wrChar & charMask;
      if (rxPush)      rxBuf  <= rxChar;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd && busAddr == DataA)      busRdata = BUS_W'(rxBuf & charMask);
    else if (busRd && busAddr == StatA) busRdata = BUS_W'(stat);
  end

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-1:CHAR_W] == '0);
endmodule

// File: rtl/uart_dri_top.sv
module uart_dri_top
  import uart_dri_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int BUS_W     = 16,
  parameter int CHAR_W    = 9,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              cfgFifoEn,
  input  logic              cfgTxDmaEn,
  input  logic              cfgRxDmaEn,
  input  logic              cfgEightBit,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txTake,
  input  logic              rxPush,
  input  logic [CHAR_W-1:0] rxChar,
  output logic              rxPop,
  input  logic              rxStartLow,
  input  logic              rxFalseStart,
  input  logic              rxPreamble
);
  dri_strobe_t strb;
  dri_status_t stat;

  assign txValid = !stat.txEmpty;
  assign rxPop   = strb.popRx;

  uart_dri_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .cfgFifoEn(cfgFifoEn), .cfgTxDmaEn(cfgTxDmaEn), .cfgRxDmaEn(cfgRxDmaEn),
    .txTake(txTake), .rxPush(rxPush), .rxStartLow(rxStartLow),
    .rxFalseStart(rxFalseStart), .rxPreamble(rxPreamble),
    .strb(strb), .stat(stat)
  );

  uart_dri_datapath #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busAddr(busAddr),
    .wrChar(busWdata[CHAR_W-1:0]), .cfgEightBit(cfgEightBit),
    .strb(strb), .stat(stat), .rxPush(rxPush), .rxChar(rxChar),
    .txData(txData), .busRdata(busRdata)
  );
endmodule

// File: tb/uart_dri_top_tb.sv
module uart_dri_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRd = 0, busWr = 0;
  logic [1:0] busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic cfgFifoEn = 0, cfgTxDmaEn = 0, cfgRxDmaEn = 0, cfgEightBit = 0;
  logic txValid;
  logic [8:0] txData;
  logic txTake = 0, rxPush = 0;
  logic [8:0] rxChar = 0;
  logic rxPop;
  logic rxStartLow = 0, rxFalseStart = 0, rxPreamble = 0;

  int checks = 0;
  int errors = 0;
  logic [15:0] rdVal;
  logic popSeen;

  always #4 clk = ~clk;

  uart_dri_top u_dut (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cfgFifoEn(cfgFifoEn),
    .cfgTxDmaEn(cfgTxDmaEn), .cfgRxDmaEn(cfgRxDmaEn), .cfgEightBit(cfgEightBit),
    .txValid(txValid), .txData(txData), .txTake(txTake), .rxPush(rxPush),
    .rxChar(rxChar), .rxPop(rxPop), .rxStartLow(rxStartLow),
    .rxFalseStart(rxFalseStart), .rxPreamble(rxPreamble)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 0; #1;
  endtask

  task automatic busRead(input logic [1:0] a);
    @(negedge clk); busRd = 1; busAddr = a; #1;
    rdVal = busRdata; popSeen = rxPop;
    @(negedge clk); busRd = 0; #1;
  endtask

  task automatic pulseTake();
    @(negedge clk); txTake = 1; @(negedge clk); txTake = 0; #1;
  endtask

  task automatic pushChar(input logic [8:0] c);
    @(negedge clk); rxPush = 1; rxChar = c; @(negedge clk); rxPush = 0; #1;
  endtask

  task automatic testReset();
    check("R1 txValid", {15'b0, txValid}, 16'h0000);
    check("R1 rxPop", {15'b0, rxPop}, 16'h0000);
    busRead(2'd0);
    check("R1 R2 status after reset", rdVal, 16'h0001);
  endtask

  task automatic testArmedWrite();
    busWrite(2'd1, 16'hFF55);
    check("R5 armed write loads", {15'b0, txValid}, 16'h0001);
    check("R5 txData", {7'b0, txData}, 16'h0155);
    busWrite(2'd1, 16'h00AA);
    check("R6 write while full ignored", {7'b0, txData}, 16'h0155);
    pulseTake();
    check("R6 take empties", {15'b0, txValid}, 16'h0000);
  endtask

  task automatic testUnarmedWrite();
    busWrite(2'd1, 16'h0077);
    check("R4 unarmed write ignored", {15'b0, txValid}, 16'h0000);
    check("R4 txData unchanged", {7'b0, txData}, 16'h0155);
    busRead(2'd0);
    busWrite(2'd1, 16'h0077);
    check("R5 rearmed write loads", {7'b0, txData}, 16'h0077);
    pulseTake();
  endtask

  task automatic testRxArming();
    pushChar(9'h1C3);
    busRead(2'd1);
    check("R7 R3 unarmed read data", rdVal, 16'h01C3);
    check("R7 no pop", {15'b0, popSeen}, 16'h0000);
    busRead(2'd0);
    check("R7 R2 full still set", rdVal, 16'h0003);
    busRead(2'd1);
    check("R8 armed read pops", {15'b0, popSeen}, 16'h0001);
    busRead(2'd0);
    check("R8 full cleared", rdVal, 16'h0001);
  endtask

  task automatic testStaleArm();
    busRead(2'd0);
    pushChar(9'h055);
    busRead(2'd1);
    check("R11 stale arm no pop", {15'b0, popSeen}, 16'h0000);
    busRead(2'd0);
    busRead(2'd1);
    check("R11 fresh arm pops", {15'b0, popSeen}, 16'h0001);
    busWrite(2'd1, 16'h0000);
    pulseTake();
  endtask

  task automatic testBypass();
    cfgTxDmaEn = 1;
    busWrite(2'd1, 16'h0011);
    check("R10 tx dma write accepted", {7'b0, txData}, 16'h0011);
    pulseTake();
    pushChar(9'h022);
    busRead(2'd1);
    check("R10 tx dma does not bypass read", {15'b0, popSeen}, 16'h0000);
    cfgTxDmaEn = 0; cfgRxDmaEn = 1;
    busRead(2'd1);
    check("R10 rx dma read pops", {15'b0, popSeen}, 16'h0001);
    busWrite(2'd1, 16'h0099);
    check("R10 rx dma does not bypass write", {15'b0, txValid}, 16'h0000);
    cfgRxDmaEn = 0; cfgFifoEn = 1;
    busWrite(2'd1, 16'h0033);
    check("R9 fifo write accepted", {7'b0, txData}, 16'h0033);
    pulseTake();
    pushChar(9'h044);
    busRead(2'd1);
    check("R9 fifo read pops", {15'b0, popSeen}, 16'h0001);
    cfgFifoEn = 0;
  endtask

  task automatic testEightBit();
    cfgEightBit = 1;
    pushChar(9'h1C3);
    busRead(2'd1);
    check("R3 eight-bit read masks bit 8", rdVal, 16'h00C3);
    busRead(2'd0);
    busWrite(2'd1, 16'h01A5);
    check("R3 eight-bit write drops bit 8", {7'b0, txData}, 16'h00A5);
    cfgEightBit = 0;
  endtask

  task automatic testRxActive();
    @(negedge clk); rxStartLow = 1; @(negedge clk); rxStartLow = 0;
    busRead(2'd0);
    check("R12 set by start low", {15'b0, rdVal[2]}, 16'h0001);
    @(negedge clk); rxFalseStart = 1; @(negedge clk); rxFalseStart = 0;
    busRead(2'd0);
    check("R12 cleared by false start", {15'b0, rdVal[2]}, 16'h0000);
    @(negedge clk); rxStartLow = 1; @(negedge clk); rxStartLow = 0;
    @(negedge clk); rxPreamble = 1; @(negedge clk); rxPreamble = 0;
    busRead(2'd0);
    check("R12 cleared by preamble", {15'b0, rdVal[2]}, 16'h0000);
    @(negedge clk); rxStartLow = 1; rxPush = 1; rxChar = 9'h001;
    @(negedge clk); rxStartLow = 0; rxPush = 0;
    busRead(2'd0);
    check("R12 clear wins over set", {15'b0, rdVal[2]}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    testReset();
    testArmedWrite();
    testUnarmedWrite();
    testRxArming();
    testStaleArm();
    testBypass();
    testEightBit();
    testRxActive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule